// File: doc/BRIEF.md
# Prescaled Core Timer with Toggle Latch

This block is a general-purpose up/down timer for a peripheral subsystem. A programmable prescaler divides the system clock. The division factor is a base factor of 4 or 8 multiplied by a power of two from 1 to 128. This gives overall factors from 4 to 1024. Each prescaled tick moves a 16-bit counter one step, either up or down. The counter runs freely in timer mode. In gated mode it runs only while an external gate input sits at a programmed level.

Every time the counter wraps, the block does two things. It emits a one-cycle event pulse, and it inverts a toggle latch. The latch state and the event pulse are exported unconditionally so that sibling timers can use them as a count source or a reload trigger. The latch also reaches an external pin, but only when the pin enable bit is set. Software sets up the block through a two-register write port with a combinational read port. The two registers are a control word and the count value.

Top module: `core_timer_top`

## Requirements
- R1: After reset the count and the control word read 0, the latch, the pin and the event output are 0.
- R2: The control word layout is mode[2:0], input select[5:3], base select[6], direction[7], run[8], gate level[9], pin enable[10], latch[11]. With mode 000 and run 1, the count moves one step every 2^(b+sel) clocks. Here b is 2 for base select 0 and 3 for base select 1. The first step lands on the 2^(b+sel)-th clock edge after the edge that set run.
- R3: Direction 0 counts up and direction 1 counts down.
- R4: Counting up past 0xFFFF to 0x0000, or down past 0x0000 to 0xFFFF, inverts the latch and raises the event output for exactly one cycle. Both changes happen on the same edge as the wrap.
- R5: With mode 001 and run 1, the prescaler and the count advance only while gate_in equals the gate level bit. Otherwise both hold their state.
- R6: With pin enable 1, tout_pin follows the latch. With pin enable 0, tout_pin is 0. tout_latch shows the latch in both cases.
- R7: A control write loads the latch from bit 11. A control write on the edge of a wrap overrides that wrap's toggle, while the event pulse is still issued.
- R8: A write to address 1 loads the count. If it lands on a tick edge, the load wins, the tick is dropped and no event or toggle occurs.
- R9: With run 0 or a mode other than 000 and 001, the count holds.
- R10: Read address 0 returns the control word with bit 11 showing the current latch. Read address 1 returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 count |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 count |
| rd_data | output | 16 | Read data (combinational) |
| gate_in | input | 1 | External gate for gated mode (synchronous to clk) |
| tout_pin | output | 1 | Latch driven to the pin when enabled |
| tout_latch | output | 1 | Latch state for sibling timers |
| tout_evt | output | 1 | One-cycle over/underflow pulse |

## Verification
Two pairs of actions can fall on the same edge. A software write can coincide with a counter wrap, or a count load can coincide with a prescaler tick. The bench times a control write to commit exactly on the wrap edge, with bit 11 set to the pre-wrap latch value. It then judges that the latch keeps the written value while the event pulse still arrives on schedule. It also times a count load onto a tick edge that would otherwise wrap. It expects the loaded value, an unchanged latch and no event pulse. Event pulses are checked against a queue of predicted edge numbers, so any unexpected pulse counts as a mismatch.

// File: rtl/ct_pkg.sv
package ct_pkg;
   localparam logic [2:0] MODE_TIMER = 3'b000;
   localparam logic [2:0] MODE_GATED = 3'b001;
   localparam int CTRL_BITS = 12;

   typedef struct packed {
      logic       latch;
      logic       pin_en;
      logic       gate_lvl;
      logic       run;
      logic       down;
      logic       base_sel;
      logic [2:0] isel;
      logic [2:0] mode;
   } ctrl_t;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
   parameter int ISEL_W       = 3,
   parameter int BASE_L2_LO   = 2,
   parameter int BASE_L2_HI   = 3,
   parameter bit HAS_BASE_SEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              gate_ok_i,
   input  logic              base_sel_i,
   input  logic [ISEL_W-1:0] isel_i,
   output logic              tick_o
);
   localparam int MAX_L2 = BASE_L2_HI + (2**ISEL_W) - 1;
   localparam int PRE_W  = MAX_L2;
   localparam int DL_W   = $clog2(PRE_W + 1) + 1;

   if (BASE_L2_LO < 1 || BASE_L2_HI < BASE_L2_LO) begin : g_bad_base
      $error("ct_prescaler: base factors must be at least 2 and ordered");
   end

   logic [PRE_W-1:0] pre_q;
   logic [DL_W-1:0]  base_l2;
   logic [DL_W-1:0]  div_l2;
   logic [PRE_W:0]   mask;
   logic             step;

   if (HAS_BASE_SEL) begin : g_base_sel
      assign base_l2 = base_sel_i ? DL_W'(BASE_L2_HI) : DL_W'(BASE_L2_LO);
   end else begin : g_base_fixed
      logic unused_sel;
      assign unused_sel = base_sel_i;
      assign base_l2    = DL_W'(BASE_L2_LO);
   end

   assign div_l2 = base_l2 + DL_W'(isel_i);
   assign mask   = ((PRE_W+1)'(1) << div_l2) - (PRE_W+1)'(1);
   assign step   = active_i && gate_ok_i;
   assign tick_o = step && ((pre_q & mask[PRE_W-1:0]) == mask[PRE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q <= '0;
      else if (!active_i) pre_q <= '0;
      else if (step)      pre_q <= pre_q + 1'b1;
   end

   // R2: the smallest division is 4, so ticks never come back to back
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
   // R5: a closed gate freezes the prescaler
   p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !gate_ok_i) |=> $stable(pre_q));
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             down_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_now_o,
   output logic             evt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             evt_q;
   logic             at_edge;

   assign at_edge    = down_i ? (cnt_q == '0) : (&cnt_q);
   assign wrap_now_o = tick_i && !load_i && at_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt_q <= 1'b0;
      end else begin
         evt_q <= wrap_now_o;
         if (load_i)      cnt_q <= load_val_i;
         else if (tick_i) cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign evt_o = evt_q;

   // R4: the event pulse lasts a single cycle
   p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |=> !evt_q);
   // R8: a load wins over a coincident tick
   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)) && !evt_q);
   // R9: without tick or load the count holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ct_toggle.sv
module ct_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic sw_wr_i,
   input  logic sw_val_i,
   output logic latch_o
);
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= 1'b0;
      else if (sw_wr_i) latch_q <= sw_val_i;
      else if (wrap_i)  latch_q <= ~latch_q;
   end

   assign latch_o = latch_q;

   // R4: a wrap without a software write inverts the latch
   p_wrap_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && !sw_wr_i) |=> (latch_q != $past(latch_q)));
   // R7: a software write takes priority over the toggle
   p_sw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_i |=> (latch_q == $past(sw_val_i)));
endmodule

// File: rtl/core_timer_top.sv
module core_timer_top #(
   parameter int CNT_W        = 16,
   parameter int ISEL_W       = 3,
   parameter int BASE_L2_LO   = 2,
   parameter int BASE_L2_HI   = 3,
   parameter bit HAS_BASE_SEL = 1'b1,
   parameter bit PIN_IDLE     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             gate_in,
   output logic             tout_pin,
   output logic             tout_latch,
   output logic             tout_evt
);
   import ct_pkg::*;

   localparam int SPARE_W = CNT_W - CTRL_BITS;

   if (CNT_W <= CTRL_BITS) begin : g_bad_width
      $error("core_timer_top: CNT_W must exceed the control field width");
   end
   if (ISEL_W != 3) begin : g_bad_isel
      $error("core_timer_top: control layout holds a 3-bit input select");
   end

   ctrl_t            ctrl_q;
   logic [SPARE_W-1:0] spare_q;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic             mode_ok;
   logic             active;
   logic             gate_ok;
   logic             tick;
   logic             wrap_now;
   logic             latch;
   logic [CNT_W-1:0] cnt;
   ctrl_t            ctrl_view;

   assign ctrl_wr = wr_en && (wr_addr == 1'b0);
   assign cnt_wr  = wr_en && (wr_addr == 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         spare_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q  <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
         spare_q <= wr_data[CNT_W-1:CTRL_BITS];
      end
   end

   assign mode_ok = (ctrl_q.mode == MODE_TIMER) || (ctrl_q.mode == MODE_GATED);
   assign active  = ctrl_q.run && mode_ok;
   assign gate_ok = (ctrl_q.mode != MODE_GATED) || (gate_in == ctrl_q.gate_lvl);

   ct_prescaler #(
      .ISEL_W      (ISEL_W),
      .BASE_L2_LO  (BASE_L2_LO),
      .BASE_L2_HI  (BASE_L2_HI),
      .HAS_BASE_SEL(HAS_BASE_SEL)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .gate_ok_i (gate_ok),
      .base_sel_i(ctrl_q.base_sel),
      .isel_i    (ctrl_q.isel),
      .tick_o    (tick)
   );

   ct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .down_i    (ctrl_q.down),
      .load_i    (cnt_wr),
      .load_val_i(wr_data),
      .cnt_o     (cnt),
      .wrap_now_o(wrap_now),
      .evt_o     (tout_evt)
   );

   ct_toggle u_tog (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (wrap_now),
      .sw_wr_i (ctrl_wr),
      .sw_val_i(wr_data[CTRL_BITS-1]),
      .latch_o (latch)
   );

   always_comb begin
      ctrl_view       = ctrl_q;
      ctrl_view.latch = latch;
   end

   assign rd_data    = rd_addr ? cnt : {spare_q, ctrl_view};
   assign tout_latch = latch;

   if (PIN_IDLE) begin : g_pin_idle_hi
      assign tout_pin = ctrl_q.pin_en ? latch : 1'b1;
   end else begin : g_pin_idle_lo
      assign tout_pin = ctrl_q.pin_en && latch;
   end

   // R9: an invalid mode or a stopped timer never produces a tick
   p_no_tick_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !tick);
   // R4: an event is always accompanied by a latch change or a software write
   p_evt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_now && !ctrl_wr) |=> (tout_evt && (tout_latch != $past(tout_latch))));
endmodule

// File: tb/tb_core_timer_top.sv
module tb_core_timer_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_addr = 1'b0;
   logic [15:0] rd_data;
   logic        gate_in = 1'b0;
   logic        tout_pin, tout_latch, tout_evt;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int last_w = 0;
   int exp_q[$];
   logic lat = 1'b0;

   core_timer_top dut (.*);

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: every event pulse must match the next predicted edge
   always @(negedge clk) begin
      if (rst_n && tout_evt) begin
         if (exp_q.size() == 0) chk("R4/R8 unexpected event", 32'(cyc), 32'hFFFF_FFFF);
         else chk("R4 event edge", 32'(cyc), 32'(exp_q.pop_front()));
      end
   end

   function automatic logic [15:0] mk(input logic [2:0] md, input logic [2:0] is,
      input logic bs, input logic dn, input logic rn, input logic gl,
      input logic pe, input logic lt);
      return {4'h0, lt, pe, gl, rn, dn, bs, is, md};
   endfunction

   task automatic wr(input logic a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      last_w = cyc;
      if (a == 1'b0) lat = d[11];
   endtask

   task automatic wr_at(input int edge_no, input logic a, input logic [15:0] d);
      while (cyc < edge_no - 1) @(negedge clk);
      wr(a, d);
   endtask

   task automatic wait_to(input int edge_no);
      while (cyc < edge_no) @(negedge clk);
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int w;
      repeat (3) @(negedge clk);
      rd(1'b1, v); chk("R1 count", v, 0);
      rd(1'b0, v); chk("R1 ctrl", v, 0);
      chk("R1 pin", tout_pin, 0); chk("R1 latch", tout_latch, 0); chk("R1 evt", tout_evt, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3 up count, divide by 4, wrap at 0xFFFF
      wr(1'b1, 16'hFFFE);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 1, 0, 0, 0));
      w = last_w; exp_q.push_back(w + 8);
      wait_to(w + 3); rd(1'b1, v); chk("R2 before first tick", v, 16'hFFFE);
      wait_to(w + 4); rd(1'b1, v); chk("R2 first tick", v, 16'hFFFF);
      wait_to(w + 8); rd(1'b1, v); chk("R3 up wrap", v, 16'h0000);
      chk("R4 latch inverted", tout_latch, 1); lat = 1'b1;
      chk("R6 pin off", tout_pin, 0);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 0, 0, 0, lat));
      repeat (20) @(negedge clk);
      rd(1'b1, v); chk("R9 stopped holds", v, 16'h0000);

      // R2/R3 down count, divide by 8*2, underflow, pin enabled
      wr(1'b1, 16'h0001);
      wr(1'b0, mk(3'b000, 3'd1, 1, 1, 1, 0, 1, lat));
      w = last_w; exp_q.push_back(w + 32);
      wait_to(w + 15); rd(1'b1, v); chk("R2 div16 before tick", v, 16'h0001);
      wait_to(w + 16); rd(1'b1, v); chk("R3 down step", v, 16'h0000);
      chk("R6 pin follows latch", tout_pin, 1);
      wait_to(w + 32); rd(1'b1, v); chk("R3 underflow", v, 16'hFFFF);
      chk("R4 latch after underflow", tout_latch, 0); lat = 1'b0;
      chk("R6 pin follows low", tout_pin, 0);
      wr(1'b0, mk(3'b000, 3'd1, 1, 1, 0, 0, 1, lat));

      // R7 software latch write; R10 readback; R6 pin disable
      wr(1'b0, mk(3'b000, 3'd5, 1, 0, 0, 1, 1, 1));
      chk("R7 sw latch", tout_latch, 1); chk("R6 pin on", tout_pin, 1);
      rd(1'b0, v); chk("R10 ctrl readback", v, mk(3'b000, 3'd5, 1, 0, 0, 1, 1, 1));
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 0, 0, 0, 1));
      chk("R6 pin idle", tout_pin, 0); chk("R6 latch still out", tout_latch, 1);

      // R5 gated mode, gate level 1
      wr(1'b1, 16'h0000);
      gate_in = 1'b0;
      wr(1'b0, mk(3'b001, 3'd0, 0, 0, 1, 1, 0, lat));
      repeat (40) @(negedge clk);
      rd(1'b1, v); chk("R5 gate closed holds", v, 16'h0000);
      gate_in = 1'b1; w = cyc;
      wait_to(w + 3); rd(1'b1, v); chk("R5 before gated tick", v, 16'h0000);
      wait_to(w + 4); rd(1'b1, v); chk("R5 gated tick", v, 16'h0001);
      gate_in = 1'b0;
      repeat (30) @(negedge clk);
      rd(1'b1, v); chk("R5 gate closed again", v, 16'h0001);

      // R9 invalid mode with run set
      wr(1'b0, mk(3'b010, 3'd0, 0, 0, 1, 0, 0, lat));
      repeat (30) @(negedge clk);
      rd(1'b1, v); chk("R9 invalid mode holds", v, 16'h0001);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 0, 0, 0, lat));

      // R7 collision: control write on the wrap edge keeps written latch
      wr(1'b1, 16'hFFFE);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 1, 0, 0, lat));
      w = last_w; exp_q.push_back(w + 8);
      wr_at(w + 8, 1'b0, mk(3'b000, 3'd0, 0, 0, 1, 0, 0, 1));
      chk("R7 write beats toggle", tout_latch, 1);
      rd(1'b1, v); chk("R7 count wrapped", v, 16'h0000);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 0, 0, 0, lat));

      // R8 collision: count load on the tick edge that would wrap
      wr(1'b1, 16'hFFFE);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 1, 0, 0, lat));
      w = last_w;
      wr_at(w + 8, 1'b1, 16'h1234);
      rd(1'b1, v); chk("R8 load wins", v, 16'h1234);
      chk("R8 no event", tout_evt, 0); chk("R8 latch kept", tout_latch, 1);
      wait_to(w + 12); rd(1'b1, v); chk("R8 counting resumes", v, 16'h1235);
      wr(1'b0, mk(3'b000, 3'd0, 0, 0, 0, 0, 0, lat));

      repeat (10) @(negedge clk);
      chk("R4 all predicted events seen", 32'(exp_q.size()), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule